// File: doc/BRIEF.md
# Fractional Clock Divider with Spread Long Periods

This block derives a slower clock from its input clock at a ratio of N + b/a input cycles per output period on average. Every output period lasts either N or N+1 input cycles. Over each run of a output periods, b of them are long and a−b are short, and the long ones are placed so that they never bunch together. The block also gives a one-cycle strobe at the start of each output period, which downstream logic can use as a synchronous tick.

The configuration is a set of plain input ports: divisor, fraction numerator and denominator, a run enable, and a gate for the clock output. Divisor and fraction are captured into shadow state only when a full run of a periods ends, or while the block is stopped. A change made mid-run therefore never shortens or stretches a period. The order of periods depends on whether the long or the short periods are the minority. With m minority and M majority periods per run, the block forms m groups. Each group holds floor(M/m) majority periods plus one minority period. The remaining M mod m majority periods close the run.

Top module: `frac_clk_div`

## Requirements
- R1: Every output period, measured between consecutive strobes, lasts N or N+1 input cycles. Over each run of a periods, the total is exactly N·a + b input cycles.
- R2: When 2·b ≤ a, a run is b groups, each of x = floor((a−b)/b) periods of N cycles followed by one period of N+1 cycles. Then (a−b) mod b further periods of N cycles follow.
- R3: When 2·b > a, a run is a−b groups, each of one period of N cycles followed by x = floor(b/(a−b)) periods of N+1 cycles. Then b mod (a−b) further periods of N+1 cycles follow.
- R4: When b = 0, a = 0 or b ≥ a, every period lasts exactly N cycles.
- R5: A divisor below 2 is treated as 2.
- R6: With the gate set, `clk_out` is high for floor(P/2) input cycles of each period of length P. The high phase starts in the strobe cycle, and the output is low for the rest of the period.
- R7: `period_strobe` is high for exactly one input cycle at the start of each output period.
- R8: Divisor and fraction values written mid-run take effect only after the current run of a periods completes. The first run after start-up begins at its first period.
- R9: Clearing `cfg_run` forces `clk_out` and `period_strobe` low from the second input cycle on. Setting it starts a new run with the values present at that moment.
- R10: While `cfg_gate` is clear, `clk_out` stays low, and strobes continue at the same period lengths.
- R11: During synchronous reset, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_div | input | DIV_W (8) | Integer divisor N |
| cfg_den | input | FRAC_W (6) | Fraction denominator a |
| cfg_num | input | FRAC_W (6) | Fraction numerator b |
| cfg_run | input | 1 | Run enable; outputs idle while clear |
| cfg_gate | input | 1 | Clock output gate; `clk_out` low while clear |
| clk_out | output | 1 | Divided clock |
| period_strobe | output | 1 | One-cycle pulse at each period start |

## Verification
A wrong group or slot index shows as a strobe spacing of N where N+1 was due, or the reverse. That mismatch appears in the first affected period, at most one run of a periods after the fault. A wrong minority/majority decision swaps the whole order pattern, and it shows within the first group. A shadow register that loads at the wrong time shows as a changed period length before the running sequence has ended. A period counter that is off shows as a wrong high-phase length or a wrong total on the very next strobe.

// File: rtl/frac_div_pkg.sv
// Shared types for the fractional clock divider.
package frac_div_pkg;
    // Ordering pattern used for one run of output periods
    typedef enum logic [1:0] {
        PAT_INT   = 2'd0,  // all periods of N cycles
        PAT_SHORT = 2'd1,  // short periods are the majority
        PAT_LONG  = 2'd2   // long periods are the majority
    } pat_e;
endpackage

// File: rtl/frac_div_plan.sv
// frac_div_plan: turns divisor and fraction into a run plan.
// Purely combinational. It picks the pattern and the group size x, the
// group count z and the tail length y. It assumes the shadow registers of
// the top capture its outputs only at a run boundary.
module frac_div_plan
    import frac_div_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int FRAC_W = 6
) (
    input  logic [DIV_W-1:0]  div_i,
    input  logic [FRAC_W-1:0] den_i,
    input  logic [FRAC_W-1:0] num_i,
    output logic [DIV_W-1:0]  n_o,
    output pat_e              pat_o,
    output logic [FRAC_W-1:0] x_o,
    output logic [FRAC_W-1:0] y_o,
    output logic [FRAC_W-1:0] z_o
);
    localparam logic [DIV_W-1:0] N_MIN = DIV_W'(2);

    logic              frac_ok;
    logic              short_major;
    logic [FRAC_W-1:0] minor_cnt;
    logic [FRAC_W-1:0] major_cnt;

    // Derive pattern, group size, tail and group count
    always_comb begin
        n_o         = (div_i < N_MIN) ? N_MIN : div_i;
        frac_ok     = (den_i != '0) && (num_i != '0) && (num_i < den_i);
        short_major = ({num_i, 1'b0} <= {1'b0, den_i});
        if (!frac_ok) begin
            pat_o     = PAT_INT;
            minor_cnt = FRAC_W'(1);
            major_cnt = '0;
        end else if (short_major) begin
            pat_o     = PAT_SHORT;
            minor_cnt = num_i;
            major_cnt = den_i - num_i;
        end else begin
            pat_o     = PAT_LONG;
            minor_cnt = den_i - num_i;
            major_cnt = num_i;
        end
        x_o = major_cnt / minor_cnt;
        y_o = major_cnt % minor_cnt;
        z_o = minor_cnt;
    end
endmodule

// File: rtl/frac_div_order.sv
// frac_div_order: walks the group, slot and tail positions of one run.
// It says whether the current period is long and whether it ends the run.
// It assumes adv_i pulses once at the last cycle of each period and that
// the plan inputs are stable for the whole run.
module frac_div_order
    import frac_div_pkg::*;
#(
    parameter int FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic              adv_i,
    input  pat_e              pat_i,
    input  logic [FRAC_W-1:0] x_i,
    input  logic [FRAC_W-1:0] y_i,
    input  logic [FRAC_W-1:0] z_i,
    output logic              long_o,
    output logic              seq_last_o
);
    logic [FRAC_W-1:0] grp_q;
    logic [FRAC_W-1:0] slot_q;
    logic              tail_q;
    logic              grp_end;
    logic              grp_final;

    // Classify the current period and detect the end of the run
    always_comb begin
        grp_end   = !tail_q && (slot_q == x_i);
        grp_final = (grp_q == z_i - FRAC_W'(1));
        unique case (pat_i)
            PAT_SHORT: long_o = tail_q ? 1'b0 : (slot_q == x_i);
            PAT_LONG:  long_o = tail_q ? 1'b1 : (slot_q != '0);
            default:   long_o = 1'b0;
        endcase
        if (pat_i == PAT_INT) begin
            seq_last_o = 1'b1;
        end else begin
            seq_last_o = (grp_end && grp_final && (y_i == '0)) ||
                         (tail_q && (slot_q == y_i - FRAC_W'(1)));
        end
    end

    // Step the position counters at each period end
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            grp_q  <= '0;
            slot_q <= '0;
            tail_q <= 1'b0;
        end else if (adv_i) begin
            if (seq_last_o) begin
                grp_q  <= '0;
                slot_q <= '0;
                tail_q <= 1'b0;
            end else if (grp_end) begin
                slot_q <= '0;
                if (grp_final) begin
                    tail_q <= 1'b1;
                end else begin
                    grp_q <= grp_q + FRAC_W'(1);
                end
            end else begin
                slot_q <= slot_q + FRAC_W'(1);
            end
        end
    end
endmodule

// File: rtl/frac_div_wave.sv
// frac_div_wave: counts input cycles within a period and drives the
// registered clock and strobe outputs. It assumes n_i >= 2, so every period
// has at least one high and one low cycle.
module frac_div_wave #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             gate_i,
    input  logic [DIV_W-1:0] n_i,
    input  logic             long_i,
    output logic             period_end_o,
    output logic             clk_o,
    output logic             strobe_o
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cyc_q;
    logic [CNT_W-1:0] plen;
    logic [CNT_W-1:0] half_len;

    // Current period length, its high phase and the last-cycle flag
    always_comb begin
        plen         = {1'b0, n_i} + CNT_W'(long_i);
        half_len     = plen >> 1;
        period_end_o = active_i && (cyc_q == plen - CNT_W'(1));
    end

    // Cycle counter within the running period
    always_ff @(posedge clk) begin
        if (!rst_n || !active_i || period_end_o) begin
            cyc_q <= '0;
        end else begin
            cyc_q <= cyc_q + CNT_W'(1);
        end
    end

    // Registered output clock and period strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_o    <= 1'b0;
            strobe_o <= 1'b0;
        end else begin
            clk_o    <= active_i && gate_i && (cyc_q < half_len);
            strobe_o <= active_i && (cyc_q == '0);
        end
    end
endmodule

// File: rtl/frac_clk_div.sv
// frac_clk_div: fractional divider of one input clock by N + b/a.
// It holds a shadow copy of the run plan that reloads while stopped or at
// the last cycle of a run. The order unit picks each period's length and
// the wave unit shapes the output. Configuration ports are taken to be
// synchronous to clk.
module frac_clk_div
    import frac_div_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [FRAC_W-1:0] cfg_den,
    input  logic [FRAC_W-1:0] cfg_num,
    input  logic              cfg_run,
    input  logic              cfg_gate,
    output logic              clk_out,
    output logic              period_strobe
);
    logic [DIV_W-1:0]  plan_n;
    pat_e              plan_pat;
    logic [FRAC_W-1:0] plan_x;
    logic [FRAC_W-1:0] plan_y;
    logic [FRAC_W-1:0] plan_z;

    logic [DIV_W-1:0]  sh_n;
    pat_e              sh_pat;
    logic [FRAC_W-1:0] sh_x;
    logic [FRAC_W-1:0] sh_y;
    logic [FRAC_W-1:0] sh_z;

    logic run_active;
    logic period_end;
    logic long_now;
    logic seq_last;
    logic plan_load;

    frac_div_plan #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_plan (
        .div_i (cfg_div),
        .den_i (cfg_den),
        .num_i (cfg_num),
        .n_o   (plan_n),
        .pat_o (plan_pat),
        .x_o   (plan_x),
        .y_o   (plan_y),
        .z_o   (plan_z)
    );

    // Shadow reload happens while stopped or at the close of a run
    always_comb begin
        plan_load = !run_active || (period_end && seq_last);
    end

    // Run flag follows the enable one cycle later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_active <= 1'b0;
        end else begin
            run_active <= cfg_run;
        end
    end

    // Shadow copy of the run plan
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_n   <= DIV_W'(2);
            sh_pat <= PAT_INT;
            sh_x   <= '0;
            sh_y   <= '0;
            sh_z   <= FRAC_W'(1);
        end else if (plan_load) begin
            sh_n   <= plan_n;
            sh_pat <= plan_pat;
            sh_x   <= plan_x;
            sh_y   <= plan_y;
            sh_z   <= plan_z;
        end
    end

    frac_div_order #(.FRAC_W(FRAC_W)) u_order (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (!run_active),
        .adv_i      (period_end),
        .pat_i      (sh_pat),
        .x_i        (sh_x),
        .y_i        (sh_y),
        .z_i        (sh_z),
        .long_o     (long_now),
        .seq_last_o (seq_last)
    );

    frac_div_wave #(.DIV_W(DIV_W)) u_wave (
        .clk          (clk),
        .rst_n        (rst_n),
        .active_i     (run_active),
        .gate_i       (cfg_gate),
        .n_i          (sh_n),
        .long_i       (long_now),
        .period_end_o (period_end),
        .clk_o        (clk_out),
        .strobe_o     (period_strobe)
    );
endmodule

// File: rtl/frac_div_chk.sv
// frac_div_chk: temporal properties of the divider outputs, bound to the
// top. It observes the internal run flag to relate idle state to outputs.
module frac_div_chk #(
    parameter int DIV_W = 8
) (
    input logic clk,
    input logic rst_n,
    input logic cfg_gate,
    input logic run_active,
    input logic clk_out,
    input logic period_strobe
);
    localparam int GAP_W = DIV_W + 2;
    localparam int MAXP  = (1 << DIV_W) + 1;

    logic [GAP_W-1:0] gap_q;

    // Cycles since the last strobe while running
    always_ff @(posedge clk) begin
        if (!rst_n || !run_active || period_strobe) begin
            gap_q <= '0;
        end else begin
            gap_q <= gap_q + GAP_W'(1);
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run_active |=> (!clk_out && !period_strobe)); // R9

    AST_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_gate |=> !clk_out); // R10

    AST_STROBE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (period_strobe && $past(cfg_gate)) |-> clk_out); // R6

    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        period_strobe |=> !period_strobe); // R7

    AST_GAP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= GAP_W'(MAXP)); // R1
endmodule

bind frac_clk_div frac_div_chk #(.DIV_W(DIV_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_gate      (cfg_gate),
    .run_active    (run_active),
    .clk_out       (clk_out),
    .period_strobe (period_strobe)
);

// File: tb/frac_clk_div_bench.sv
module frac_clk_div_bench;
    localparam int DIV_W  = 8;
    localparam int FRAC_W = 6;
    localparam int NV     = 8;
    localparam int VN [NV] = '{4, 3, 5, 1, 6, 7, 2, 9};
    localparam int VA [NV] = '{1, 5, 7, 4, 6, 3, 10, 0};
    localparam int VB [NV] = '{0, 2, 5, 1, 3, 5, 9, 0};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DIV_W-1:0]  cfg_div = '0;
    logic [FRAC_W-1:0] cfg_den = '0;
    logic [FRAC_W-1:0] cfg_num = '0;
    logic              cfg_run = 1'b0;
    logic              cfg_gate = 1'b1;
    logic              clk_out;
    logic              period_strobe;

    int checks = 0;
    int failures = 0;
    int wd_cnt = 0;

    always #2 clk = ~clk;

    frac_clk_div #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_frac_clk_div (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_div       (cfg_div),
        .cfg_den       (cfg_den),
        .cfg_num       (cfg_num),
        .cfg_run       (cfg_run),
        .cfg_gate      (cfg_gate),
        .clk_out       (clk_out),
        .period_strobe (period_strobe)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk) begin
        wd_cnt <= wd_cnt + 1;
        if (wd_cnt > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", wd_cnt);
            summary();
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit is_frac(input int a, input int b);
        return (a != 0) && (b != 0) && (b < a);
    endfunction

    function automatic int eff_n(input int n);
        return (n < 2) ? 2 : n;
    endfunction

    // Expected period length from the ordering rules of R2/R3/R4
    function automatic int exp_len(input int n_in, input int a, input int b, input int k_in);
        int n = eff_n(n_in);
        int k, z, x, g;
        if (!is_frac(a, b)) return n;
        k = k_in % a;
        if (2 * b <= a) begin
            z = b; x = (a - b) / b; g = x + 1;
            if (k < z * g) return ((k % g) == x) ? n + 1 : n;
            return n;
        end
        z = a - b; x = b / (a - b); g = x + 1;
        if (k < z * g) return ((k % g) == 0) ? n : n + 1;
        return n + 1;
    endfunction

    function automatic string tag_of(input int n, input int a, input int b);
        if (!is_frac(a, b)) return "R4";
        if (n < 2) return "R5";
        if (2 * b <= a) return "R2";
        return "R3";
    endfunction

    task automatic wait_strobe();
        while (!period_strobe) @(negedge clk);
    endtask

    // Called at a negedge showing a strobe; returns at the next one
    task automatic measure(output int len, output int high);
        len = 0; high = 0;
        do begin
            len++;
            high += int'(clk_out);
            @(negedge clk);
        end while (!period_strobe);
    endtask

    initial begin
        int len, high, total, seq, sc, hc;
        cfg_run = 1'b1;
        cfg_div = 8'd4; cfg_den = 6'd1;
        repeat (3) @(negedge clk);
        check("R11 clk_out in reset", int'(clk_out), 0);
        check("R11 strobe in reset", int'(period_strobe), 0);
        cfg_run = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 idle clk_out", int'(clk_out), 0);

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            cfg_run = 1'b0;
            repeat (4) @(negedge clk);
            cfg_div = DIV_W'(VN[v]); cfg_den = FRAC_W'(VA[v]); cfg_num = FRAC_W'(VB[v]);
            cfg_run = 1'b1;
            wait_strobe();
            seq = is_frac(VA[v], VB[v]) ? VA[v] : 4;
            total = 0;
            for (int k = 0; k < 2 * seq; k++) begin
                int e;
                e = exp_len(VN[v], VA[v], VB[v], k);
                measure(len, high);
                check($sformatf("%s R8 vec%0d period%0d", tag_of(VN[v], VA[v], VB[v]), v, k), len, e);
                check($sformatf("R6 vec%0d high%0d", v, k), high, e / 2);
                if (k < seq) total += len;
            end
            check($sformatf("R1 vec%0d total", v), total,
                  eff_n(VN[v]) * seq + (is_frac(VA[v], VB[v]) ? VB[v] : 0));
        end

        // Mid-run change waits for the end of the run
        cfg_run = 1'b0;
        repeat (4) @(negedge clk);
        cfg_div = 8'd3; cfg_den = 6'd5; cfg_num = 6'd2; cfg_run = 1'b1;
        wait_strobe();
        measure(len, high);
        check("R8 first period", len, 3);
        cfg_div = 8'd10; cfg_den = 6'd1; cfg_num = 6'd0;
        measure(len, high); check("R8 old p1", len, 4);
        measure(len, high); check("R8 old p2", len, 3);
        measure(len, high); check("R8 old p3", len, 4);
        measure(len, high); check("R8 old p4", len, 3);
        measure(len, high); check("R8 new value", len, 10);

        // Clearing run silences both outputs
        cfg_run = 1'b0;
        repeat (2) @(negedge clk);
        sc = 0; hc = 0;
        for (int i = 0; i < 20; i++) begin
            sc += int'(period_strobe); hc += int'(clk_out);
            @(negedge clk);
        end
        check("R9 strobes when stopped", sc, 0);
        check("R9 clk_out when stopped", hc, 0);

        // Gate clear: clock low, strobes continue
        cfg_div = 8'd4; cfg_den = 6'd1; cfg_num = 6'd0;
        cfg_gate = 1'b0; cfg_run = 1'b1;
        wait_strobe();
        repeat (3) @(negedge clk);
        sc = 0; hc = 0;
        for (int i = 0; i < 40; i++) begin
            sc += int'(period_strobe); hc += int'(clk_out);
            @(negedge clk);
        end
        check("R10 gated clk_out", hc, 0);
        check("R10 R7 strobes in 40 cycles", sc, 10);
        cfg_gate = 1'b1;
        wait_strobe();
        measure(len, high);
        check("R6 high after ungate", high, 2);

        summary();
        $finish;
    end
endmodule